// File: doc/BRIEF.md
# Optical-Flow Gradient Tile Unit

This block turns two padded image windows into the three derivative planes that a gradient-based motion estimator needs. Each call takes a window of (N+2)×(N+2) pixels from the current frame and the same-sized window from the following frame. Both windows are flattened row by row onto one wide bus, and pixel i sits at bits [i*32 +: 32]. For every pixel of the N×N interior, the block forms a horizontal central difference and a vertical central difference from the current frame, and a temporal forward difference between the two frames. All three planes are computed in parallel in a single cycle.

The input and output are both valid/ready streams. A window pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. The three result planes then appear one cycle later with `out_valid` high. Back-pressure works like a single register slice. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the results and `out_valid` are frozen and no new input is taken. Results are never lost or overwritten before they are consumed. If no new transfer arrives, the results stay on the outputs after consumption with `out_valid` low. Differences are 32-bit two's-complement subtractions that wrap modulo 2^32.

Top module: `flow_grad_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and all three result buses are zero.
- R2: With W = N+2, the horizontal plane element k*N+l (bits [(k*N+l)*32 +: 32] of `dx_out`) equals cur[(k+1)*W+l+2] − cur[(k+1)*W+l].
- R3: The vertical plane element k*N+l of `dy_out` equals cur[(k+2)*W+l+1] − cur[k*W+l+1].
- R4: The temporal plane element k*N+l of `dt_out` equals nxt[(k+1)*W+l+1] − cur[(k+1)*W+l+1].
- R5: Every difference is truncated to 32 bits and wraps modulo 2^32, including operands near 0x7FFFFFFF mixed with operands near 0x80000000.
- R6: A transfer accepted at a clock edge (in_valid and in_ready both 1) raises `out_valid` after that edge, with the results for that window pair.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and all result buses hold their values.
- R8: With `out_ready` held at 1, a new window pair can be accepted every cycle, and each result follows its input by exactly one cycle.
- R9: When the output is consumed and no transfer is accepted, `out_valid` falls to 0 and the result buses keep their last values.
- R10: For a ramp where pixel i has value i in both frames, every horizontal result is 2, every vertical result is 2W (10 for N=3), and every temporal result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window pair on the input buses is offered |
| in_ready | output | 1 | Block can take a window pair this cycle |
| cur_win | input | (N+2)*(N+2)*32 | Current-frame window, row-major, pixel i at [i*32 +: 32] |
| nxt_win | input | (N+2)*(N+2)*32 | Next-frame window, same layout |
| out_valid | output | 1 | Result planes hold a result that has not yet been consumed |
| out_ready | input | 1 | Downstream takes the result this cycle |
| dx_out | output | N*N*32 | Horizontal gradient plane, element k*N+l at [(k*N+l)*32 +: 32] |
| dy_out | output | N*N*32 | Vertical gradient plane |
| dt_out | output | N*N*32 | Temporal gradient plane |

## Verification
Acceptance of a new window pair and consumption of the pending result can happen at the same edge. The bench provokes this by streaming window pairs back to back with `out_ready` held high. At each step it requires `in_ready` to stay high and the outputs to show the newest pair's gradients one cycle later, with nothing lost or repeated. It also checks the other side of this case. An input is offered while the output is stalled, and the bench confirms that the pair is held off, the old results stay frozen, and the pair enters on the very edge where `out_ready` returns.

// File: rtl/flow_grad_pkg.sv
package flow_grad_pkg;

  typedef enum logic [1:0] {
    GD_HORIZ = 2'd0,
    GD_VERT  = 2'd1,
    GD_TIME  = 2'd2
  } grad_dir_e;

  // Index of the pixel subtracted from (the "plus" tap) for interior (k,l).
  function automatic int plus_tap(input grad_dir_e dir, input int k,
                                  input int l, input int w);
    case (dir)
      GD_HORIZ: plus_tap = (k + 1) * w + l + 2;
      GD_VERT:  plus_tap = (k + 2) * w + l + 1;
      default:  plus_tap = (k + 1) * w + l + 1;
    endcase
  endfunction

  // Index of the subtrahend ("minus" tap), always in the current frame.
  function automatic int minus_tap(input grad_dir_e dir, input int k,
                                   input int l, input int w);
    case (dir)
      GD_HORIZ: minus_tap = (k + 1) * w + l;
      GD_VERT:  minus_tap = k * w + l + 1;
      default:  minus_tap = (k + 1) * w + l + 1;
    endcase
  endfunction

endpackage

// File: rtl/fg_diff_lane.sv
module fg_diff_lane #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] plus_op,
  input  logic [PW-1:0] minus_op,
  output logic [PW-1:0] diff_q
);

  logic [PW-1:0] diff_d;

  // Width-truncated subtraction: wraps modulo 2^PW (R5).
  assign diff_d = plus_op - minus_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    diff_q <= '0;
    else if (load) diff_q <= diff_d;
  end

endmodule

// File: rtl/fg_grad_plane.sv
module fg_grad_plane
  import flow_grad_pkg::*;
#(
  parameter int        N   = 3,
  parameter int        PW  = 32,
  parameter grad_dir_e DIR = GD_HORIZ
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [(N+2)*(N+2)*PW-1:0]   cur_win,
  input  logic [(N+2)*(N+2)*PW-1:0]   nxt_win,
  output logic [N*N*PW-1:0]           plane_q
);

  localparam int W = N + 2;

  for (genvar k = 0; k < N; k++) begin : g_row
    for (genvar l = 0; l < N; l++) begin : g_col
      localparam int PI = plus_tap(DIR, k, l, W);
      localparam int MI = minus_tap(DIR, k, l, W);
      localparam int OI = k * N + l;

      logic [PW-1:0] plus_op;

      // Temporal plane takes its plus tap from the next frame (R4),
      // spatial planes from the current frame (R2, R3).
      if (DIR == GD_TIME) begin : g_next
        assign plus_op = nxt_win[PI*PW +: PW];
      end else begin : g_cur
        assign plus_op = cur_win[PI*PW +: PW];
      end

      fg_diff_lane #(.PW(PW)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .plus_op  (plus_op),
        .minus_op (cur_win[MI*PW +: PW]),
        .diff_q   (plane_q[OI*PW +: PW])
      );
    end
  end

endmodule

// File: rtl/fg_flow_ctrl.sv
module fg_flow_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready,
  output logic take
);

  logic valid_q;

  assign in_ready  = !valid_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid_q <= 1'b0;
    else if (take)      valid_q <= 1'b1;
    else if (out_ready) valid_q <= 1'b0;
  end

  // R6: an accepted transfer produces a valid result next cycle.
  assert_accept_gives_valid_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

  // R7: a stalled result stays valid.
  assert_stall_keeps_valid_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid);

  // R9: consumed and not refilled -> valid drops.
  assert_drain_drops_valid_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/flow_grad_unit.sv
module flow_grad_unit
  import flow_grad_pkg::*;
#(
  parameter int N  = 3,
  parameter int PW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [(N+2)*(N+2)*PW-1:0]  cur_win,
  input  logic [(N+2)*(N+2)*PW-1:0]  nxt_win,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [N*N*PW-1:0]          dx_out,
  output logic [N*N*PW-1:0]          dy_out,
  output logic [N*N*PW-1:0]          dt_out
);

  logic take;

  fg_flow_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .take      (take)
  );

  fg_grad_plane #(.N(N), .PW(PW), .DIR(GD_HORIZ)) u_dx (
    .clk(clk), .rst_n(rst_n), .load(take),
    .cur_win(cur_win), .nxt_win(nxt_win), .plane_q(dx_out));

  fg_grad_plane #(.N(N), .PW(PW), .DIR(GD_VERT)) u_dy (
    .clk(clk), .rst_n(rst_n), .load(take),
    .cur_win(cur_win), .nxt_win(nxt_win), .plane_q(dy_out));

  fg_grad_plane #(.N(N), .PW(PW), .DIR(GD_TIME)) u_dt (
    .clk(clk), .rst_n(rst_n), .load(take),
    .cur_win(cur_win), .nxt_win(nxt_win), .plane_q(dt_out));

  // R7 / R9: without an accepted transfer the result planes do not move.
  assert_hold_without_accept_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=>
        ($stable(dx_out) && $stable(dy_out) && $stable(dt_out)));

  // R7: a stalled output refuses new input.
  assert_stall_blocks_input_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/flow_grad_unit_bench.sv
module flow_grad_unit_bench;
  localparam int N  = 3;
  localparam int PW = 32;
  localparam int W  = N + 2;
  localparam int NI = W * W;
  localparam int NO = N * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              in_valid = 1'b0;
  logic              out_ready = 1'b1;
  logic [NI*PW-1:0]  cur_win = '0;
  logic [NI*PW-1:0]  nxt_win = '0;
  logic              in_ready, out_valid;
  logic [NO*PW-1:0]  dx_out, dy_out, dt_out;

  flow_grad_unit #(.N(N), .PW(PW)) u_flow_grad_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cur_win(cur_win), .nxt_win(nxt_win), .out_valid(out_valid),
    .out_ready(out_ready), .dx_out(dx_out), .dy_out(dy_out), .dt_out(dt_out));

  int checks = 0;
  int fails  = 0;
  logic [PW-1:0] ca [NI];
  logic [PW-1:0] na [NI];
  logic [PW-1:0] seed = 32'h1234_5678;
  logic [NO*PW-1:0] ex, ey, et;

  task automatic chk_vec(input string req, input logic [NO*PW-1:0] act,
                         input logic [NO*PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive_and_model();
    for (int i = 0; i < NI; i++) begin
      cur_win[i*PW +: PW] = ca[i];
      nxt_win[i*PW +: PW] = na[i];
    end
    for (int k = 0; k < N; k++) begin
      for (int l = 0; l < N; l++) begin
        ex[(k*N+l)*PW +: PW] = ca[(k+1)*W+l+2] - ca[(k+1)*W+l];
        ey[(k*N+l)*PW +: PW] = ca[(k+2)*W+l+1] - ca[k*W+l+1];
        et[(k*N+l)*PW +: PW] = na[(k+1)*W+l+1] - ca[(k+1)*W+l+1];
      end
    end
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < NI; i++) begin
      if (v == 0) begin
        ca[i] = i; na[i] = i;
      end else if (v == 1) begin
        ca[i] = (i % 2 == 0) ? 32'h7FFF_FF00 + i : 32'h8000_0000 + i;
        na[i] = 32'h8000_0010 + i;
      end else if (v == 2) begin
        ca[i] = (i % 2 == 0) ? 32'h8000_0000 + i : 32'h7FFF_FFF0 - i;
        na[i] = 32'h7FFF_FFFF - i;
      end else if (v == 3) begin
        ca[i] = (i % 3 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000;
        na[i] = (i % 2 == 0) ? 32'h0000_0001 : 32'hFFFF_FFFE;
      end else begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        ca[i] = seed;
        seed = seed * 32'd1664525 + 32'd1013904223;
        na[i] = seed;
      end
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [NO*PW-1:0] hx, hy, ht;
    logic [NO*PW-1:0] k2, k10;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_bit("R1 out_valid", out_valid, 1'b0);
    chk_vec("R1 dx", dx_out, '0);
    chk_vec("R1 dy", dy_out, '0);
    chk_vec("R1 dt", dt_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R1 in_ready", in_ready, 1'b1);

    // R8: back-to-back stream, one result per cycle; R2/R3/R4/R5/R6 per vector
    out_ready = 1'b1;
    for (int v = 0; v < 200; v++) begin
      fill(v);
      drive_and_model();
      in_valid = 1'b1;
      @(negedge clk);
      chk_bit("R6 out_valid", out_valid, 1'b1);
      chk_bit("R8 in_ready", in_ready, 1'b1);
      chk_vec((v >= 1 && v <= 3) ? "R5 R2 dx wrap" : "R2 dx", dx_out, ex);
      chk_vec((v >= 1 && v <= 3) ? "R5 R3 dy wrap" : "R3 dy", dy_out, ey);
      chk_vec((v >= 1 && v <= 3) ? "R5 R4 dt wrap" : "R4 dt", dt_out, et);
      if (v == 0) begin
        for (int i = 0; i < NO; i++) begin
          k2[i*PW +: PW]  = 32'd2;
          k10[i*PW +: PW] = 32'd10;
        end
        chk_vec("R10 ramp dx", dx_out, k2);
        chk_vec("R10 ramp dy", dy_out, k10);
        chk_vec("R10 ramp dt", dt_out, '0);
      end
    end

    // R9: drain with no new input
    in_valid = 1'b0;
    hx = ex; hy = ey; ht = et;
    @(negedge clk);
    chk_bit("R9 out_valid drop", out_valid, 1'b0);
    chk_vec("R9 dx hold", dx_out, hx);
    chk_vec("R9 dt hold", dt_out, ht);
    cur_win = ~cur_win;
    @(negedge clk);
    chk_vec("R9 dy ignores idle input", dy_out, hy);

    // R7: stall — first pair A accepted, second pair B held off
    out_ready = 1'b0;
    fill(1000);
    drive_and_model();
    hx = ex; hy = ey; ht = et;
    in_valid = 1'b1;
    @(negedge clk);
    chk_bit("R6 stall accept", out_valid, 1'b1);
    fill(1001);
    drive_and_model();
    chk_bit("R7 in_ready low", in_ready, 1'b0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk_bit("R7 valid held", out_valid, 1'b1);
      chk_vec("R7 dx held", dx_out, hx);
      chk_vec("R7 dy held", dy_out, hy);
      chk_vec("R7 dt held", dt_out, ht);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R8 release valid", out_valid, 1'b1);
    chk_vec("R8 release dx", dx_out, ex);
    chk_vec("R8 release dy", dy_out, ey);
    chk_vec("R8 release dt", dt_out, et);
    @(negedge clk);
    chk_bit("R9 final drop", out_valid, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule